// File: doc/BRIEF.md
# Hysteretic Weighted Threshold Gate

This block models one threshold gate of a null convention logic netlist in a clocked, synthesizable form. It watches a vector of single-rail inputs, each carrying a small integer weight. When the total weight of the high inputs reaches a threshold, the output goes high. From then on the output keeps its value while any input is still high, and it returns low only after every input has gone low. This hold behaviour is the hysteresis that lets a dual-rail wavefront complete before the gate can take part in the next one.

The top module takes the input count, the threshold and a packed weight vector as parameters. A selector parameter picks how the set condition is built. The default builds it as a generic weighted sum compared with the threshold. Two fixed three-input variants build it as direct sum-of-products logic instead: a 2-of-3 majority gate, and a threshold-3 gate whose first input weighs 2. The state bit is a register that updates on every clock edge and clears on a synchronous reset. There is no streaming data path, so every pin is a plain level signal and nothing exerts back-pressure.

Top module: `thresh_hyst_gate`

## Requirements
- R1: While `rst_i` is high at a clock edge, `out_o` becomes 0 after that edge, whatever the inputs are.
- R2: In the weighted variant (`KIND` = 0), input bit i has the weight held in `WEIGHTS[4*i+3:4*i]`. If the sum of the weights of the high inputs is at least `M`, `out_o` is 1 after the next clock edge. A total below `M` never sets a low output.
- R3: With the default parameters (N=4, M=3, bit 0 weight 2, bits 1 to 3 weight 1), the output sets when bit 0 is high together with any other bit, or when bits 1, 2 and 3 are all high.
- R4: While `out_o` is 1, it stays 1 as long as at least one input bit is high, even when the weighted total is below `M`.
- R5: `out_o` falls to 0 after the first clock edge at which all input bits are 0.
- R6: Once the output has cleared, a pattern below the threshold does not set it again.
- R7: With `KIND` = 1 (N=3), the set condition is any two of the three inputs high together: bits 0 and 1, bits 1 and 2, or bits 0 and 2.
- R8: With `KIND` = 2 (N=3), the set condition is bit 0 high together with bit 1 or bit 2. Bits 1 and 2 high without bit 0 do not set the output.
- R9: The output changes only at clock edges. An input change shows up at `out_o` after exactly one rising edge.
- R10: At elaboration, every weight must be at least 1, `M` must lie between 1 and the sum of all weights, and the fixed variants must have N=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| in_i | input | N | Single-rail gate inputs |
| out_o | output | 1 | Registered gate output with hysteresis |

## Verification
The bound checker watches the hysteresis rules on every cycle. Reset forces a low output. An all-zero input clears the output. A high output with any input still high stays high. The output never rises unless some input was high one cycle earlier. Which input patterns count as reaching the threshold, the weighting of bit 0, and the differences between the three set-condition variants depend on particular patterns. Only the bench's vector table and its directed sequences can show those.

// File: rtl/thg_pkg.sv
package thg_pkg;
  localparam int unsigned THG_WW = 4;

  typedef enum logic [1:0] {
    THG_WEIGHTED     = 2'd0,
    THG_TWO_OF_THREE = 2'd1,
    THG_W2_THREE     = 2'd2
  } thg_kind_e;

  function automatic int unsigned thg_sum_width(input int unsigned n);
    return $clog2(n * ((1 << THG_WW) - 1) + 1);
  endfunction
endpackage

// File: rtl/thg_weight_sum.sv
module thg_weight_sum #(
  parameter int unsigned N       = 4,
  parameter int unsigned WW      = 4,
  parameter logic [N*WW-1:0] WEIGHTS = '0,
  parameter int unsigned SW      = 8
) (
  input  logic [N-1:0]  in_i,
  output logic [SW-1:0] sum_o
);
  logic [SW-1:0] partial [N+1];

  assign partial[0] = '0;
  for (genvar i = 0; i < N; i++) begin : g_acc
    localparam logic [WW-1:0] W_I = WEIGHTS[i*WW +: WW];
    assign partial[i+1] = partial[i] + (in_i[i] ? SW'(W_I) : '0);
  end
  assign sum_o = partial[N];
endmodule

// File: rtl/thg_set_logic.sv
module thg_set_logic
  import thg_pkg::*;
#(
  parameter thg_kind_e   KIND    = THG_WEIGHTED,
  parameter int unsigned N       = 4,
  parameter int unsigned M       = 3,
  parameter logic [N*THG_WW-1:0] WEIGHTS = '0
) (
  input  logic [N-1:0] in_i,
  output logic         set_o
);
  localparam int unsigned SW = thg_sum_width(N);

  if (KIND == THG_WEIGHTED) begin : g_weighted
    logic [SW-1:0] total;
    thg_weight_sum #(.N(N), .WW(THG_WW), .WEIGHTS(WEIGHTS), .SW(SW)) u_sum (
      .in_i (in_i),
      .sum_o(total)
    );
    assign set_o = (total >= SW'(M));
  end else if (KIND == THG_TWO_OF_THREE) begin : g_maj
    assign set_o = (in_i[0] & in_i[1]) | (in_i[1] & in_i[2]) | (in_i[0] & in_i[2]);
  end else begin : g_w2
    assign set_o = in_i[0] & (in_i[1] | in_i[2]);
  end
endmodule

// File: rtl/thg_hold_cell.sv
module thg_hold_cell (
  input  logic clk_i,
  input  logic rst_i,
  input  logic set_i,
  input  logic any_i,
  output logic q_o
);
  logic q_next;
  always_comb q_next = set_i | (q_o & any_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) q_o <= 1'b0;
    else       q_o <= q_next;
  end
endmodule

// File: rtl/thresh_hyst_gate.sv
module thresh_hyst_gate
  import thg_pkg::*;
#(
  parameter thg_kind_e   KIND    = THG_WEIGHTED,
  parameter int unsigned N       = 4,
  parameter int unsigned M       = 3,
  parameter logic [N*THG_WW-1:0] WEIGHTS = 16'h1112
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [N-1:0] in_i,
  output logic         out_o
);
  function automatic int unsigned weight_total();
    int unsigned t = 0;
    for (int i = 0; i < int'(N); i++) t += int'(WEIGHTS[i*THG_WW +: THG_WW]);
    return t;
  endfunction

  function automatic bit weights_legal();
    for (int i = 0; i < int'(N); i++)
      if (WEIGHTS[i*THG_WW +: THG_WW] == '0) return 1'b0;
    return 1'b1;
  endfunction

  localparam int unsigned W_TOTAL = weight_total();
  localparam bit          W_OK    = weights_legal();

  // R10: parameter legality at elaboration
  initial begin
    assert (W_OK && M >= 1 && M <= W_TOTAL)
      else $error("thresh_hyst_gate: illegal weights or threshold");
    assert (KIND == THG_WEIGHTED || N == 3)
      else $error("thresh_hyst_gate: fixed variants need three inputs");
  end

  logic set_w;
  logic any_w;

  thg_set_logic #(.KIND(KIND), .N(N), .M(M), .WEIGHTS(WEIGHTS)) u_set (
    .in_i (in_i),
    .set_o(set_w)
  );

  assign any_w = |in_i;

  thg_hold_cell u_hold (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .set_i(set_w),
    .any_i(any_w),
    .q_o  (out_o)
  );
endmodule

// File: rtl/thg_checker.sv
module thg_checker #(
  parameter int unsigned N = 4
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic [N-1:0] in_i,
  input logic         out_o
);
  AST_RESET_CLEARS: assert property (@(posedge clk_i) rst_i |=> !out_o); // R1
  AST_IDLE_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_i == '0) |=> !out_o); // R5
  AST_HOLD_WHILE_ACTIVE: assert property (@(posedge clk_i) disable iff (rst_i)
    (out_o && (in_i != '0)) |=> out_o); // R4
  AST_RISE_NEEDS_INPUT: assert property (@(posedge clk_i) disable iff (rst_i)
    (!out_o && (in_i == '0)) |=> !out_o); // R9
endmodule

bind thresh_hyst_gate thg_checker #(.N(N)) u_thg_chk (
  .clk_i(clk_i),
  .rst_i(rst_i),
  .in_i (in_i),
  .out_o(out_o)
);

// File: tb/thresh_hyst_gate_tb_top.sv
`timescale 1ns/1ps
module thresh_hyst_gate_tb_top;
  import thg_pkg::*;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] in4;
  logic [2:0] in23, in33;
  logic       out4, out23, out33;
  int         n_tests = 0;
  int         n_fail  = 0;

  always #2.5 clk = ~clk;

  thresh_hyst_gate dut_i (.clk_i(clk), .rst_i(rst), .in_i(in4), .out_o(out4));
  thresh_hyst_gate #(.KIND(THG_TWO_OF_THREE), .N(3), .M(2), .WEIGHTS(12'h111)) dut_maj_i (
    .clk_i(clk), .rst_i(rst), .in_i(in23), .out_o(out23));
  thresh_hyst_gate #(.KIND(THG_W2_THREE), .N(3), .M(3), .WEIGHTS(12'h112)) dut_w2_i (
    .clk_i(clk), .rst_i(rst), .in_i(in33), .out_o(out33));

  // Each entry: {rst, in[3:0], expected out, requirement number}
  localparam int NV = 13;
  localparam logic [9:0] VEC [NV] = '{
    {1'b1, 4'b0000, 1'b0, 4'd1},  // R1 reset
    {1'b0, 4'b0001, 1'b0, 4'd2},  // R2 bit0 alone totals 2
    {1'b0, 4'b0011, 1'b1, 4'd3},  // R3 bit0 + bit1
    {1'b0, 4'b0001, 1'b1, 4'd4},  // R4 below threshold, holds
    {1'b0, 4'b0000, 1'b0, 4'd5},  // R5 all zero clears
    {1'b0, 4'b0010, 1'b0, 4'd6},  // R6 total 1
    {1'b0, 4'b0110, 1'b0, 4'd6},  // R6 total 2
    {1'b0, 4'b1110, 1'b1, 4'd3},  // R3 bits 1..3
    {1'b0, 4'b1000, 1'b1, 4'd4},  // R4 single input holds
    {1'b0, 4'b0000, 1'b0, 4'd5},  // R5
    {1'b0, 4'b1001, 1'b1, 4'd3},  // R3 bit0 + bit3
    {1'b1, 4'b1001, 1'b0, 4'd1},  // R1 reset beats set
    {1'b0, 4'b1001, 1'b1, 4'd2}   // R2
  };

  task automatic check(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step3(input logic [2:0] a, input logic [2:0] b);
    @(negedge clk);
    in23 = a;
    in33 = b;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; in4 = '0; in23 = '0; in33 = '0;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset state", out4, 1'b0);
    check("R1 reset state maj", out23, 1'b0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      rst = VEC[v][9];
      in4 = VEC[v][8:5];
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[v][3:0], v), out4, VEC[v][4]);
    end

    // R9: a change is not visible before the clock edge
    @(negedge clk);
    rst = 1'b0; in4 = 4'b0000;
    @(negedge clk);
    in4 = 4'b0011;
    #1;
    check("R9 no change before edge", out4, 1'b0);
    @(negedge clk);
    check("R9 change after one edge", out4, 1'b1);

    // R7: two-of-three variant
    step3(3'b011, 3'b000); check("R7 bits 0,1", out23, 1'b1);
    step3(3'b001, 3'b000); check("R7 hold (R4)", out23, 1'b1);
    step3(3'b000, 3'b000); check("R7 clear (R5)", out23, 1'b0);
    step3(3'b100, 3'b000); check("R7 single no set", out23, 1'b0);
    step3(3'b101, 3'b000); check("R7 bits 0,2", out23, 1'b1);
    step3(3'b000, 3'b000);
    step3(3'b110, 3'b000); check("R7 bits 1,2", out23, 1'b1);

    // R8: weighted three-input variant
    step3(3'b000, 3'b110); check("R8 bits 1,2 no set", out33, 1'b0);
    step3(3'b000, 3'b011); check("R8 bits 0,1", out33, 1'b1);
    step3(3'b000, 3'b110); check("R8 hold (R4)", out33, 1'b1);
    step3(3'b000, 3'b000); check("R8 clear (R5)", out33, 1'b0);
    step3(3'b000, 3'b001); check("R8 bit0 alone", out33, 1'b0);
    step3(3'b000, 3'b101); check("R8 bits 0,2", out33, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule